// File: doc/BRIEF.md
# Shared-Source Interrupt Front End

This block sits between a handful of raw event signals and an interrupt controller. Each of two shared request lines can take its event from one of two candidates. Line 0 picks between a port pin and a low-voltage-detect flag. Line 1 picks between a second port pin and a comparator output. The choice comes from a byte-wide select register. A rising edge on the chosen signal sets a pending flag for that line. The flag stays set until the CPU acknowledges that line.

The block also holds the master interrupt enable. Instruction strobes for enable, disable and return-from-interrupt change it, and so does any acknowledge and any write to the control register. A request output is raised only when its line is pending and the master enable is on. Edges are taken after the source multiplexer. Software should therefore turn the line off (or tolerate a spurious request) before it changes the selection.

Top module: `irq_share_front`

## Requirements
- R1: Select register bit 7 picks the source of line 0: 0 selects `pin_a`, 1 selects `lvd_flag`.
- R2: Select register bit 6 picks the source of line 1: 0 selects `pin_b`, 1 selects `cmp_flag`.
- R3: A 0-to-1 change of a line's multiplexed signal between two consecutive clock edges sets that line's pending flag. This includes a change caused only by rewriting the select register.
- R4: The select register lives at address 0xFCE and the control register at 0xFCF. A read returns its byte on `rd_data` one cycle after `rd_en`, and `rd_data` holds between reads. A read of any other address returns 0x00.
- R5: With `rst` high, both registers become 0x00, the pending flags and last-level copies become 0, and `irq_req`, `irq_en` and `rd_data` become 0.
- R6: The master enable (control bit 7, output `irq_en`) becomes 1 on `ei_stb`, on `reti_stb`, or on a control write with bit 7 = 1.
- R7: The master enable becomes 0 on `di_stb`, on any set bit of `ack`, or on a control write with bit 7 = 0.
- R8: When a clearing event and a setting event of the master enable fall in the same cycle, the enable ends at 0.
- R9: `irq_req[i]` in a cycle equals the pending flag of line i ANDed with the master enable, as both stood one clock earlier. Pending flags are still captured while the enable is 0.
- R10: A pending flag holds until `ack[i]` is high at a clock edge, which clears it. An `ack[i]` in the same cycle as a rising edge on that line leaves the flag at 0.
- R11: Reads return 0 in select bits 5:0 and control bits 6:0, whatever was written there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| pin_a | input | 1 | Port pin candidate for line 0 |
| lvd_flag | input | 1 | Low-voltage-detect candidate for line 0 |
| pin_b | input | 1 | Port pin candidate for line 1 |
| cmp_flag | input | 1 | Comparator candidate for line 1 |
| ei_stb | input | 1 | Enable-interrupts instruction strobe |
| di_stb | input | 1 | Disable-interrupts instruction strobe |
| reti_stb | input | 1 | Return-from-interrupt strobe |
| ack | input | 2 | Per-line CPU acknowledge |
| irq_req | output | 2 | Request to the interrupt controller, one bit per line |
| irq_en | output | 1 | Master interrupt enable |

## Verification
Two kinds of collision can happen in one cycle. The master enable can be cleared by a disable strobe, an acknowledge or a write of 0 while an enable, a return or a write of 1 sets it. A line's acknowledge can also arrive on the same edge as a fresh rising edge on that line. The bench sweeps every combination of the three strobes, the two acknowledge bits and the three write cases, starting from both enable states. It reads the control register back and compares it with the rule that clearing wins. In the source sweep, acknowledges are mixed with level steps, so many clears land on an edge. The bench then watches whether the request reappears once the enable returns.

// File: rtl/irq_share_pkg.sv
package irq_share_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 12;
  localparam int N_LINES = 2;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_SEL  = 2'd1,
    ACC_CTL  = 2'd2
  } acc_e;

  function automatic acc_e decode_acc(input logic [ADDR_W-1:0] a,
                                      input logic [ADDR_W-1:0] sel_a,
                                      input logic [ADDR_W-1:0] ctl_a);
    if (a == sel_a)      return ACC_SEL;
    else if (a == ctl_a) return ACC_CTL;
    else                 return ACC_NONE;
  endfunction
endpackage

// File: rtl/irq_share_regs.sv
module irq_share_regs
  import irq_share_pkg::*;
#(
  parameter int                  LINES    = N_LINES,
  parameter logic [ADDR_W-1:0]   SEL_ADDR = 12'hFCE,
  parameter logic [ADDR_W-1:0]   CTL_ADDR = 12'hFCF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ei_stb,
  input  logic              di_stb,
  input  logic              reti_stb,
  input  logic              ack_any,
  output logic [LINES-1:0]  sel_o,
  output logic              gie_o,
  output logic [DATA_W-1:0] rd_data
);
  localparam int TOP = DATA_W - 1;
  localparam int RSV = DATA_W - LINES;

  acc_e             acc;
  logic [LINES-1:0] sel_q;
  logic             gie_q;
  logic             wr_sel, wr_ctl;
  logic             gie_clr, gie_set;
  logic [DATA_W-1:0] sel_view, ctl_view;
  logic [RSV-2:0]    wdata_unused;

  assign acc     = decode_acc(addr, SEL_ADDR, CTL_ADDR);
  assign wr_sel  = wr_en && (acc == ACC_SEL);
  assign wr_ctl  = wr_en && (acc == ACC_CTL);
  assign gie_clr = di_stb || ack_any || (wr_ctl && !wr_data[TOP]);
  assign gie_set = ei_stb || reti_stb || (wr_ctl && wr_data[TOP]);
  assign wdata_unused = wr_data[RSV-2:0];

  always_comb begin
    sel_view = '0;
    for (int i = 0; i < LINES; i++) sel_view[TOP-i] = sel_q[i];
    ctl_view      = '0;
    ctl_view[TOP] = gie_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
    end else if (wr_sel) begin
      for (int i = 0; i < LINES; i++) sel_q[i] <= wr_data[TOP-i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          gie_q <= 1'b0;
    else if (gie_clr) gie_q <= 1'b0;
    else if (gie_set) gie_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      unique case (acc)
        ACC_SEL: rd_data <= sel_view;
        ACC_CTL: rd_data <= ctl_view;
        default: rd_data <= '0;
      endcase
    end
  end

  assign sel_o = sel_q;
  assign gie_o = gie_q;

  a_r8_clear_wins: assert property (@(posedge clk) disable iff (rst)
    (di_stb || ack_any) |=> !gie_o);
  a_r6_set_enable: assert property (@(posedge clk) disable iff (rst)
    ((ei_stb || reti_stb) && !di_stb && !ack_any && !wr_ctl) |=> gie_o);
  a_r7_write_zero: assert property (@(posedge clk) disable iff (rst)
    (wr_ctl && !wr_data[TOP]) |=> !gie_o);
  a_r11_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> (rd_data[RSV-1:0] == '0));
endmodule

// File: rtl/irq_share_edge.sv
module irq_share_edge (
  input  logic clk,
  input  logic rst,
  input  logic pin_src,
  input  logic alt_src,
  input  logic use_alt,
  input  logic ack,
  input  logic gie,
  output logic req
);
  logic cur, prev_q, pend_q, rise;

  assign cur  = use_alt ? alt_src : pin_src;
  assign rise = cur && !prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
      req    <= 1'b0;
    end else begin
      prev_q <= cur;
      if (ack)       pend_q <= 1'b0;
      else if (rise) pend_q <= 1'b1;
      req <= pend_q && gie;
    end
  end

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !ack) |=> pend_q);
  a_r10_ack_clears: assert property (@(posedge clk) disable iff (rst)
    ack |=> !pend_q);
  a_r3_rise_sets: assert property (@(posedge clk) disable iff (rst)
    (cur && !prev_q && !ack) |=> pend_q);
  a_r9_gate: assert property (@(posedge clk) disable iff (rst)
    !gie |=> !req);
endmodule

// File: rtl/irq_share_front.sv
module irq_share_front
  import irq_share_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              pin_a,
  input  logic              lvd_flag,
  input  logic              pin_b,
  input  logic              cmp_flag,
  input  logic              ei_stb,
  input  logic              di_stb,
  input  logic              reti_stb,
  input  logic [N_LINES-1:0] ack,
  output logic [N_LINES-1:0] irq_req,
  output logic              irq_en
);
  logic [N_LINES-1:0] sel;
  logic [N_LINES-1:0] pin_v, alt_v;
  logic               gie;

  assign pin_v  = {pin_b, pin_a};
  assign alt_v  = {cmp_flag, lvd_flag};
  assign irq_en = gie;

  irq_share_regs #(
    .LINES(N_LINES), .SEL_ADDR(12'hFCE), .CTL_ADDR(12'hFCF)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .ei_stb(ei_stb), .di_stb(di_stb),
    .reti_stb(reti_stb), .ack_any(|ack), .sel_o(sel), .gie_o(gie),
    .rd_data(rd_data)
  );

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    irq_share_edge u_edge (
      .clk(clk), .rst(rst), .pin_src(pin_v[g]), .alt_src(alt_v[g]),
      .use_alt(sel[g]), .ack(ack[g]), .gie(gie), .req(irq_req[g])
    );
  end
endmodule

// File: tb/irq_share_front_test.sv
module irq_share_front_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] A_SEL = 12'hFCE;
  localparam logic [11:0] A_CTL = 12'hFCF;

  logic clk = 0, rst = 1, wr_en = 0, rd_en = 0;
  logic [11:0] addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic pin_a = 0, lvd_flag = 0, pin_b = 0, cmp_flag = 0;
  logic ei_stb = 0, di_stb = 0, reti_stb = 0;
  logic [1:0] ack = '0, irq_req;
  logic irq_en;

  int n_tests = 0, n_fail = 0;
  logic [1:0] m_sel = 0, m_prev = 0, m_pend = 0, m_req = 0;
  logic m_gie = 0;
  logic [7:0] m_rdata = 0;

  irq_share_front uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .pin_a(pin_a), .lvd_flag(lvd_flag),
    .pin_b(pin_b), .cmp_flag(cmp_flag), .ei_stb(ei_stb), .di_stb(di_stb),
    .reti_stb(reti_stb), .ack(ack), .irq_req(irq_req), .irq_en(irq_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input string tag);
    logic [1:0] cur, rise, n_pend, n_req, n_sel;
    logic n_gie, clr, set;
    logic [7:0] n_rd;
    @(posedge clk);
    if (rst) begin
      m_sel = 0; m_gie = 0; m_prev = 0; m_pend = 0; m_req = 0; m_rdata = 0;
    end else begin
      cur[0] = m_sel[0] ? lvd_flag : pin_a;
      cur[1] = m_sel[1] ? cmp_flag : pin_b;
      rise   = cur & ~m_prev;
      n_req  = m_pend & {2{m_gie}};
      n_pend = (m_pend | rise) & ~ack;
      n_rd   = m_rdata;
      if (rd_en) begin
        if (addr == A_SEL)      n_rd = {m_sel[0], m_sel[1], 6'b0};
        else if (addr == A_CTL) n_rd = {m_gie, 7'b0};
        else                    n_rd = 8'h00;
      end
      n_sel = m_sel;
      if (wr_en && addr == A_SEL) n_sel = {wr_data[6], wr_data[7]};
      clr = di_stb || (|ack) || (wr_en && addr == A_CTL && !wr_data[7]);
      set = ei_stb || reti_stb || (wr_en && addr == A_CTL && wr_data[7]);
      n_gie = clr ? 1'b0 : (set ? 1'b1 : m_gie);
      m_prev = cur; m_pend = n_pend; m_req = n_req; m_rdata = n_rd;
      m_sel = n_sel; m_gie = n_gie;
    end
    #1;
    chk(tag, "irq_req", {6'b0, irq_req}, {6'b0, m_req});
    chk(tag, "irq_en", {7'b0, irq_en}, {7'b0, m_gie});
    chk(tag, "rd_data", rd_data, m_rdata);
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d, input string tag);
    wr_en = 1; addr = a; wr_data = d; cyc(tag); wr_en = 0;
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    rd_en = 1; addr = a; cyc(tag); rd_en = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R5: reset state
    rst = 1; cyc("R5"); cyc("R5"); rst = 0; cyc("R5");
    rd(A_SEL, "R5"); rd(A_CTL, "R5");

    // R4 / R11: addressing and reserved bits
    wr(A_SEL, 8'hFF, "R4"); rd(A_SEL, "R11");
    wr(A_CTL, 8'hFF, "R6"); rd(A_CTL, "R11");
    rd(12'h123, "R4"); cyc("R4");
    wr(A_CTL, 8'h7F, "R7"); rd(A_CTL, "R7");

    // R1 / R2 / R3 / R10: sweep all selects and level transitions
    for (int s = 0; s < 4; s++) begin
      wr(A_SEL, 8'(s << 6), "R1");
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          reti_stb = 1;
          {cmp_flag, pin_b, lvd_flag, pin_a} = 4'(a);
          cyc("R1"); reti_stb = 0;
          {cmp_flag, pin_b, lvd_flag, pin_a} = 4'(b);
          ack = 2'(b >> 2) & 2'(a);
          cyc("R10"); ack = 0;
          cyc("R2");
          ack = {2{a[0] ^ b[1]}};
          cyc("R3"); ack = 0;
        end
      end
      rd(A_SEL, "R1");
    end

    // R3: selection change alone raises a request
    pin_a = 0; lvd_flag = 1; pin_b = 0; cmp_flag = 1;
    wr(A_SEL, 8'h00, "R3"); ack = 2'b11; cyc("R3"); ack = 0;
    reti_stb = 1; cyc("R3"); reti_stb = 0;
    wr(A_SEL, 8'h80, "R3"); cyc("R3"); cyc("R3");
    wr(A_SEL, 8'hC0, "R3"); cyc("R3"); cyc("R3");

    // R6 / R7 / R8: every strobe and write combination from both states
    for (int g = 0; g < 2; g++) begin
      for (int c = 0; c < 96; c++) begin
        wr(A_CTL, g[0] ? 8'h80 : 8'h00, "R7");
        {ei_stb, di_stb, reti_stb, ack} = 5'(c);
        if (c >= 32) begin
          wr_en = 1; addr = A_CTL; wr_data = (c >= 64) ? 8'h80 : 8'h00;
        end
        cyc("R8");
        wr_en = 0; {ei_stb, di_stb, reti_stb, ack} = '0;
        rd(A_CTL, "R6");
      end
    end

    // R9: pending captured while the enable is off, shown once enabled
    ack = 2'b11; cyc("R9"); ack = 0;
    wr(A_SEL, 8'h00, "R9");
    pin_a = 0; pin_b = 0; cyc("R9");
    di_stb = 1; cyc("R9"); di_stb = 0;
    pin_a = 1; pin_b = 1; cyc("R9"); cyc("R9"); cyc("R9");
    ei_stb = 1; cyc("R9"); ei_stb = 0;
    cyc("R9"); cyc("R9");
    ack = 2'b01; cyc("R10"); ack = 0; cyc("R10"); cyc("R10");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule